// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status state of a downstream port that supports hot-plug. Software programs it through a simple configuration write/read port (dword address, byte enables, data). Card insertion, card removal and attention-button presses arrive as one-cycle input pulses. The block records each event in a status bit and tells software about it. In message mode it raises a one-cycle message request carrying a 5-bit message number. In legacy mode it drives a level-sensitive interrupt line instead.

Every write that touches the control half of the register completes at once, so it raises the command-completed event in the same cycle. Writing 1 to the interlock control bit flips the interlock status, and the control bit itself always reads back 0. While the interlock is engaged, insertion and removal requests are refused with a busy pulse.

A two-bit state machine `slot_state_e` tracks the presence and interlock condition of the slot. It has four states:
- SLOT_FREE
- SLOT_FILLED
- SLOT_FREE_LOCKED
- SLOT_FILLED_LOCKED

Its transitions are:
- **insert**: FREE or FILLED to FILLED.
- **remove**: FILLED or FREE to FREE.
- **lock toggle**: any state to the same presence state with the lock flag inverted. This can combine with an insert or remove in an unlocked state.
- **soft reset**: any state to the same presence state, unlocked.

In the two LOCKED states only the lock toggle and the soft reset are taken. Insert and remove are refused there.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After `rst_n` is asserted, a read of the slot register returns 0x0000_00F0: both indicators off, all enables, events, presence and interlock 0. `msg_req`, `intx_out` and `plug_busy` are 0.
- R2: Status event bits sit at 16 (attention button), 17 (presence changed) and 18 (command completed). Each event sets its bit. Writing 1 with byte enable 2 clears it, and a set in the same cycle wins over the clear. Writes to bit 19 (presence state) and bit 20 (interlock status) have no effect.
- R3: Control bits 0..2 enable the events at status bits 16..18, and bit 3 is the hot-plug interrupt enable. In message mode (`msg_mode`=1), an event whose status bit was clear raises a single-cycle `msg_req` carrying `msg_vec`, when bit 3 and its own enable are set after that cycle's write. An event whose status bit is already set raises no request.
- R4: In legacy mode, `intx_out` follows the level bit3 AND OR(enables AND event status), recomputed every cycle. It is always 0 in message mode.
- R5: Any write to the slot register with byte enable 0 or 1 sets command-completed (bit 18). The result is visible on the next read.
- R6: Writing 1 to bit 8 with byte enable 1 toggles the interlock status (bit 20). Bit 8 always reads 0.
- R7: In message mode, a control write raises `msg_req` when bit 3 is set after the write and some enable goes 0 to 1 while its event status bit is already set.
- R8: While the interlock is engaged, an insert or remove pulse is refused. `plug_busy` pulses in the next cycle, and presence state and presence-changed are unchanged.
- R9: An accepted insert sets presence state (bit 19) and presence-changed. An accepted remove clears presence state and sets presence-changed.
- R10: A `soft_rst` cycle has the following effects:
  - Control returns to 0x00F0.
  - Interlock status and the three event bits clear.
  - Presence state is kept.
- R11: The attention indicator is at bits 5:4 and the power indicator at bits 7:6, coded 01 on, 10 blink, 11 off. Writing the reserved code 00 leaves a field unchanged. Bits 15:9 and 31:21 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous slot reset that keeps presence state |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after `cfg_rd` |
| msg_mode | input | 1 | 1 selects message notification, 0 the legacy line |
| msg_vec | input | MSG_W | Message number to attach to requests |
| card_insert | input | 1 | Insertion request pulse |
| card_remove | input | 1 | Removal request pulse |
| attn_press | input | 1 | Attention button pulse |
| plug_busy | output | 1 | Refused insert/remove (interlock engaged) |
| msg_req | output | 1 | One-cycle notification message request |
| msg_req_vec | output | MSG_W | Message number of the request |
| intx_out | output | 1 | Legacy interrupt level |

## Verification
The assertions check the following on every cycle:
- Command completion follows each control write.
- Each interlock toggle flips the lock.
- Presence never moves while locked, and busy only appears when locked.
- The legacy level never rises without an enabled pending event.
- A soft reset leaves the defined image.

The rest needs the directed scenarios:
- Edge-qualified message rules: no repeat on an already-set event, and a message on an enable that rises over a pending event.
- Write-1-to-clear racing with new events.
- The reserved indicator code.
- The full register image seen through reads.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int EV_W     = 3;
    localparam int EV_ABP   = 0;
    localparam int EV_PDC   = 1;
    localparam int EV_CC    = 2;
    localparam int CTL_W    = 8;
    localparam int C_HPIE   = 3;
    localparam int C_IND_LO = 4;
    localparam int NUM_IND  = 2;
    localparam int C_LOCK   = 8;
    localparam int S_BASE   = 16;
    localparam logic [1:0] IND_RSVD = 2'b00;
    localparam logic [CTL_W-1:0] CTL_RST = 8'hF0;

    typedef enum logic [1:0] {
        SLOT_FREE          = 2'b00,
        SLOT_FILLED        = 2'b01,
        SLOT_FREE_LOCKED   = 2'b10,
        SLOT_FILLED_LOCKED = 2'b11
    } slot_state_e;
endpackage

// File: rtl/hp_slot_fsm.sv
module hp_slot_fsm
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic insert,
    input  logic remove,
    input  logic lock_toggle,
    output logic present,
    output logic locked,
    output logic pd_event,
    output logic busy
);
    slot_state_e state_q, state_d;
    logic        accept;
    logic        busy_q;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        if (soft_rst) begin
            unique case (state_q)
                SLOT_FREE, SLOT_FREE_LOCKED:     state_d = SLOT_FREE;
                SLOT_FILLED, SLOT_FILLED_LOCKED: state_d = SLOT_FILLED;
            endcase
        end else begin
            unique case (state_q)
                SLOT_FREE: begin
                    accept = 1'b1;
                    if (insert)
                        state_d = lock_toggle ? SLOT_FILLED_LOCKED : SLOT_FILLED;
                    else if (lock_toggle)
                        state_d = SLOT_FREE_LOCKED;
                end
                SLOT_FILLED: begin
                    accept = 1'b1;
                    if (insert)
                        state_d = lock_toggle ? SLOT_FILLED_LOCKED : SLOT_FILLED;
                    else if (remove)
                        state_d = lock_toggle ? SLOT_FREE_LOCKED : SLOT_FREE;
                    else if (lock_toggle)
                        state_d = SLOT_FILLED_LOCKED;
                end
                SLOT_FREE_LOCKED: begin
                    if (lock_toggle) state_d = SLOT_FREE;
                end
                SLOT_FILLED_LOCKED: begin
                    if (lock_toggle) state_d = SLOT_FILLED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            busy_q  <= !soft_rst && !accept && (insert || remove);
        end
    end

    always_comb begin
        present  = (state_q == SLOT_FILLED) || (state_q == SLOT_FILLED_LOCKED);
        locked   = (state_q == SLOT_FREE_LOCKED) || (state_q == SLOT_FILLED_LOCKED);
        pd_event = accept && (insert || remove);
        busy     = busy_q;
    end
endmodule

// File: rtl/hp_ctl_regs.sv
module hp_ctl_regs
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_wr,
    input  logic             lane0,
    input  logic             lane1,
    input  logic [C_LOCK:0]  wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [CTL_W-1:0] ctl_d,
    output logic             lock_toggle
);
    always_comb begin
        ctl_d = ctl_q;
        if (soft_rst) begin
            ctl_d = CTL_RST;
        end else if (ctl_wr && lane0) begin
            ctl_d[C_HPIE:0] = wdata[C_HPIE:0];
            for (int i = 0; i < NUM_IND; i++) begin
                if (wdata[C_IND_LO+2*i +: 2] != IND_RSVD)
                    ctl_d[C_IND_LO+2*i +: 2] = wdata[C_IND_LO+2*i +: 2];
            end
        end
        lock_toggle = !soft_rst && ctl_wr && lane1 && wdata[C_LOCK];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/hp_notify.sv
module hp_notify
    import hp_slot_pkg::*;
#(
    parameter int MSG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             msg_mode,
    input  logic [MSG_W-1:0] msg_vec,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_q,
    input  logic [CTL_W-1:0] ctl_d,
    input  logic [EV_W-1:0]  ev_set,
    input  logic [EV_W-1:0]  ev_clr,
    output logic [EV_W-1:0]  sts_q,
    output logic             msg_req,
    output logic [MSG_W-1:0] msg_req_vec,
    output logic             intx
);
    logic [EV_W-1:0] sts_d, new_ev, en_q, en_d;
    logic            hpie_d, ev_fire, rise_fire;

    always_comb begin
        en_q      = ctl_q[EV_W-1:0];
        en_d      = ctl_d[EV_W-1:0];
        hpie_d    = ctl_d[C_HPIE];
        sts_d     = soft_rst ? '0 : ((sts_q & ~ev_clr) | ev_set);
        new_ev    = ev_set & ~sts_q;
        ev_fire   = hpie_d && |(new_ev & en_d);
        rise_fire = ctl_wr && hpie_d && |(~en_q & en_d & sts_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q       <= '0;
            msg_req     <= 1'b0;
            msg_req_vec <= '0;
            intx        <= 1'b0;
        end else begin
            sts_q       <= sts_d;
            msg_req     <= !soft_rst && msg_mode && (ev_fire || rise_fire);
            msg_req_vec <= msg_vec;
            intx        <= !soft_rst && !msg_mode && hpie_d && |(en_d & sts_d);
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] SLOT_ADDR = 10'h02D,
    parameter int                MSG_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              msg_mode,
    input  logic [MSG_W-1:0]  msg_vec,
    input  logic              card_insert,
    input  logic              card_remove,
    input  logic              attn_press,
    output logic              plug_busy,
    output logic              msg_req,
    output logic [MSG_W-1:0]  msg_req_vec,
    output logic              intx_out
);
    logic             hit, ctl_wr, sts_wr, lock_toggle;
    logic             present, locked, pd_event;
    logic [CTL_W-1:0] ctl_q, ctl_d;
    logic [EV_W-1:0]  sts_q, ev_set, ev_clr;
    logic [31:0]      image;

    always_comb begin
        hit    = (cfg_addr == SLOT_ADDR);
        ctl_wr = cfg_wr && hit && (cfg_be[0] || cfg_be[1]);
        sts_wr = cfg_wr && hit && cfg_be[2];
        ev_clr = sts_wr ? cfg_wdata[S_BASE +: EV_W] : '0;
        ev_set = soft_rst ? '0 : {ctl_wr, pd_event, attn_press};
        image  = {11'b0, locked, present, sts_q, 8'b0, ctl_q};
    end

    hp_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_wr(ctl_wr),
        .lane0(cfg_be[0]), .lane1(cfg_be[1]), .wdata(cfg_wdata[C_LOCK:0]),
        .ctl_q(ctl_q), .ctl_d(ctl_d), .lock_toggle(lock_toggle)
    );

    hp_slot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .insert(card_insert),
        .remove(card_remove), .lock_toggle(lock_toggle), .present(present),
        .locked(locked), .pd_event(pd_event), .busy(plug_busy)
    );

    hp_notify #(.MSG_W(MSG_W)) u_notify (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .msg_mode(msg_mode),
        .msg_vec(msg_vec), .ctl_wr(ctl_wr), .ctl_q(ctl_q), .ctl_d(ctl_d),
        .ev_set(ev_set), .ev_clr(ev_clr), .sts_q(sts_q), .msg_req(msg_req),
        .msg_req_vec(msg_req_vec), .intx(intx_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= (cfg_rd && hit) ? image : '0;
    end
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       msg_mode,
    input logic       msg_req,
    input logic       intx_out,
    input logic       plug_busy,
    input logic       ctl_wr,
    input logic       lock_toggle,
    input logic       present,
    input logic       locked,
    input logic [7:0] ctl,
    input logic [2:0] sts
);
    // R3
    msg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(msg_mode));
    // R4
    intx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_out |-> (ctl[3] && |(ctl[2:0] & sts)));
    // R5
    cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr && !soft_rst) |-> sts[2]);
    // R6
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_toggle) |-> (locked != $past(locked)));
    // R8
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> (present == $past(present)));
    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plug_busy |-> $past(locked));
    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (ctl == 8'hF0 && sts == 3'b000 && !locked
                             && present == $past(present)));
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .msg_mode(msg_mode),
    .msg_req(msg_req), .intx_out(intx_out), .plug_busy(plug_busy),
    .ctl_wr(ctl_wr), .lock_toggle(lock_toggle), .present(present),
    .locked(locked), .ctl(ctl_q), .sts(sts_q)
);

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;
    localparam logic [9:0] ADDR = 10'h02D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [9:0]  cfg_addr = ADDR;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        msg_mode = 1'b0;
    logic [4:0]  msg_vec = 5'd19;
    logic        card_insert = 1'b0, card_remove = 1'b0, attn_press = 1'b0;
    logic        plug_busy, msg_req, intx_out;
    logic [4:0]  msg_req_vec;

    int checks = 0, fails = 0, msg_cnt = 0, busy_cnt = 0;
    logic [4:0] last_vec = '0;
    bit done = 0;

    always #4 clk = ~clk;

    hp_slot_ctrl u_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
        .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_mode(msg_mode),
        .msg_vec(msg_vec), .card_insert(card_insert), .card_remove(card_remove),
        .attn_press(attn_press), .plug_busy(plug_busy), .msg_req(msg_req),
        .msg_req_vec(msg_req_vec), .intx_out(intx_out)
    );

    always @(posedge clk) begin
        if (msg_req) begin
            msg_cnt  <= msg_cnt + 1;
            last_vec <= msg_req_vec;
        end
        if (plug_busy) busy_cnt <= busy_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic chk_reg(input string tag, input logic [31:0] mask, input logic [31:0] exp);
        @(negedge clk); cfg_rd = 1'b1;
        @(negedge clk); cfg_rd = 1'b0;
        chk(tag, cfg_rdata & mask, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_attn();
        @(negedge clk); attn_press = 1'b1; @(negedge clk); attn_press = 1'b0; settle();
    endtask

    task automatic pulse_ins();
        @(negedge clk); card_insert = 1'b1; @(negedge clk); card_insert = 1'b0; settle();
    endtask

    task automatic pulse_rem();
        @(negedge clk); card_remove = 1'b1; @(negedge clk); card_remove = 1'b0; settle();
    endtask

    task automatic t_reset();
        chk_reg("R1 image", 32'hFFFF_FFFF, 32'h0000_00F0);
        chk("R1 outputs", {29'b0, intx_out, msg_req, plug_busy}, 32'h0);
    endtask

    task automatic t_indicators();
        wr(4'b0001, 32'h0000_0050);
        chk_reg("R5 cc after ctl write", 32'hFFFF_FFFF, 32'h0004_0050);
        wr(4'b0001, 32'h0000_0090);
        chk_reg("R11 blink/on", 32'hFFFF_FFFF, 32'h0004_0090);
        wr(4'b1111, 32'hFFFF_FE00);
        chk_reg("R11 reserved code and bits", 32'hFFFF_FFFF, 32'h0004_0090);
        wr(4'b0100, 32'h0004_0000);
        chk_reg("R2 w1c cc", 32'hFFFF_FFFF, 32'h0000_0090);
    endtask

    task automatic t_legacy();
        wr(4'b0001, 32'h0000_009F);
        settle();
        chk("R4 intx on cc", {31'b0, intx_out}, 32'd1);
        wr(4'b0100, 32'h0004_0000);
        settle();
        chk("R4 intx drops on clear", {31'b0, intx_out}, 32'd0);
        pulse_attn();
        chk("R4 intx on attn", {31'b0, intx_out}, 32'd1);
        chk("R4 no msg in legacy", msg_cnt, 32'd0);
        wr(4'b0100, 32'h0001_0000);
        settle();
        chk("R4 intx off", {31'b0, intx_out}, 32'd0);
        chk_reg("R2 status clear", 32'h001F_0000, 32'h0);
    endtask

    task automatic t_msg();
        @(negedge clk); msg_mode = 1'b1;
        pulse_attn();
        chk("R3 one msg", msg_cnt, 32'd1);
        chk("R3 vector", {27'b0, last_vec}, 32'd19);
        chk("R4 intx zero in msg mode", {31'b0, intx_out}, 32'd0);
        pulse_attn();
        chk("R3 no repeat while set", msg_cnt, 32'd1);
        wr(4'b0100, 32'h0001_0000);
        @(negedge clk); msg_vec = 5'd7;
        pulse_attn();
        chk("R3 second msg", msg_cnt, 32'd2);
        chk("R3 new vector", {27'b0, last_vec}, 32'd7);
        wr(4'b0100, 32'h0007_0000);
        settle();
    endtask

    task automatic t_rise();
        wr(4'b0001, 32'h0000_0098);
        settle();
        chk("R3 cc not enabled", msg_cnt, 32'd2);
        pulse_attn();
        chk("R3 abp not enabled", msg_cnt, 32'd2);
        wr(4'b0001, 32'h0000_0099);
        settle();
        chk("R7 enable rise", msg_cnt, 32'd3);
        wr(4'b0001, 32'h0000_0099);
        settle();
        chk("R7 no rise no msg", msg_cnt, 32'd3);
        wr(4'b0100, 32'h0007_0000);
        @(negedge clk); msg_mode = 1'b0;
    endtask

    task automatic t_lock();
        pulse_ins();
        chk_reg("R9 insert", 32'h001A_0000, 32'h000A_0000);
        wr(4'b0010, 32'h0000_0100);
        chk_reg("R6 lock on", 32'h0010_01FF, 32'h0010_0099);
        wr(4'b0100, 32'h0002_0000);
        pulse_rem();
        chk("R8 busy on remove", busy_cnt, 32'd1);
        chk_reg("R8 presence held", 32'h000A_0000, 32'h0008_0000);
        pulse_ins();
        chk("R8 busy on insert", busy_cnt, 32'd2);
        wr(4'b0010, 32'h0000_0100);
        chk_reg("R6 lock off", 32'h0010_0100, 32'h0);
        pulse_rem();
        chk_reg("R9 remove", 32'h000A_0000, 32'h0002_0000);
        chk("R9 no busy", busy_cnt, 32'd2);
    endtask

    task automatic t_softrst();
        pulse_ins();
        wr(4'b0010, 32'h0000_0100);
        wr(4'b0001, 32'h0000_005F);
        pulse_attn();
        @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk_reg("R10 image", 32'hFFFF_FFFF, 32'h0008_00F0);
        chk("R10 intx", {31'b0, intx_out}, 32'd0);
        pulse_rem();
        chk_reg("R10 unlocked after", 32'h0018_0000, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indicators();
        t_legacy();
        t_msg();
        t_rise();
        t_lock();
        t_softrst();
        finish_run();
    end

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule